// File: doc/BRIEF.md
# Strided Bit Gather Unit

The unit takes a 128-bit vector operand and a 3-bit stride N and builds a 64-bit scalar from every Nth bit of the operand. Bit positions are counted from the most significant end, starting at zero, so the operand bits at positions 0, N, 2N and so on are chosen. The chosen bits are packed left-justified into the result, and every result bit below them is zero. For a legal stride the packed field is ceil(128/N) bits long. It fills all 64 bits when N is 2 and only the top 19 bits when N is 7.

The operand is treated as two 64-bit halves. Each half goes through its own staged mask-shift-or compaction network. Before compaction, the lower half is shifted left by N·ceil(64/N)−64 so that the stride pattern carries on across the boundary between the halves. The bits gathered from the lower half are then placed directly below the ceil(64/N) bits gathered from the upper half. The result is registered, and a write-enable tells the downstream register file whether to take it.

A small controller has three states, each named for what the output holds:
- ST_IDLE: nothing was issued on the previous clock.
- ST_WRITE: a legal stride was issued on the previous clock.
- ST_SKIP: an illegal stride (0 or 1) was issued on the previous clock.

The next state does not depend on the current state, so every state can move to any of the three:
- in_valid high with a stride of 2 or more goes to ST_WRITE.
- in_valid high with a stride below 2 goes to ST_SKIP.
- in_valid low goes to ST_IDLE.
- Reset forces ST_IDLE.

Top module: `gnb_unit`

## Requirements
- R1: When in_valid is high and stride is between 2 and 7, out_valid and wr_en are both high on the next clock; wr_en is never high without out_valid.
- R2: For a legal stride N, one clock after issue, result[63−j] equals operand[127−j·N] for every j with j·N < 128.
- R3: For a legal stride N, every result bit below the top ceil(128/N) bits is zero (all 64 bits are used for N=2, the top 19 for N=7).
- R4: The stride pattern continues across the 64-bit boundary: for N=3, operand[61] (position 66) lands in result[41]; for N=5, operand[62] lands in result[50]; for N=7, operand[57] lands in result[53].
- R5: When in_valid is high with stride 0 or 1, out_valid is high on the next clock, wr_en is low and result keeps its previous value.
- R6: When in_valid is low, out_valid and wr_en are low on the next clock and result keeps its previous value.
- R7: A synchronous active-high reset clears out_valid, wr_en and result to zero, whatever in_valid is doing.
- R8: Issues on consecutive clocks with different strides and operands each produce their own result one clock later, with no effect from the issue before them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand and stride are presented this cycle |
| operand | input | 128 | Source vector, bit 127 is position 0 |
| stride | input | 3 | Gather stride N; 2 to 7 are legal |
| out_valid | output | 1 | A result slot follows an issue by one clock |
| wr_en | output | 1 | Destination should be written with result |
| result | output | 64 | Left-justified gathered bits, zero below |

## Verification
The bench builds the unit with its default widths: a 64-bit half, a 128-bit operand and a 3-bit stride. With these widths all eight stride codes can be driven, including the two illegal ones that must leave the destination untouched. Every stage of the five-stage compaction network is used, and the boundary alignment shift is non-zero for strides 3, 5, 6 and 7. Under these values the single-bit probes near position 64 and the all-ones operands decide whether the boundary continuation and the zero tail are correct.

// File: rtl/gnb_pkg.sv
`timescale 1ns/1ps
package gnb_pkg;

    localparam int STRIDE_MIN = 2;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WRITE = 2'd1,
        ST_SKIP  = 2'd2
    } gnb_state_e;

    function automatic int ceil_div(int a, int b);
        return (a + b - 1) / b;
    endfunction

endpackage

// File: rtl/gnb_compact.sv
`timescale 1ns/1ps
module gnb_compact #(
    parameter int DW     = 64,
    parameter int NW     = 3,
    parameter int STAGES = 5
) (
    input  logic [NW-1:0] stride,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout
);
    import gnb_pkg::*;

    localparam int NCODES = 2 ** NW;
    localparam int SHW    = NW + STAGES;

    // Keep groups of 2^s bits that start every n*2^s bits, counted from the MSB.
    function automatic logic [DW-1:0] stage_mask(int n, int s);
        logic [DW-1:0] m;
        m = '0;
        for (int k = 0; k < DW; k++) begin
            if ((k % (n << s)) < (1 << s)) m[DW-1-k] = 1'b1;
        end
        return m;
    endfunction

    logic [DW-1:0] lvl [STAGES+1];

    assign lvl[0] = din;

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        logic [DW-1:0]  cand [NCODES];
        logic [DW-1:0]  kept;
        logic [SHW-1:0] sh;

        for (genvar v = 0; v < NCODES; v++) begin : g_code
            if (v >= STRIDE_MIN) begin : g_legal
                assign cand[v] = stage_mask(v, s);
            end else begin : g_illegal
                assign cand[v] = '0;
            end
        end

        assign kept       = lvl[s] & cand[stride];
        assign sh         = (SHW'(stride) - SHW'(1)) << s;
        assign lvl[s+1]   = kept | (kept << sh);
    end

    assign dout = lvl[STAGES];

endmodule

// File: rtl/gnb_align.sv
`timescale 1ns/1ps
module gnb_align #(
    parameter int DW = 64,
    parameter int NW = 3,
    parameter int CW = 7
) (
    input  logic [NW-1:0] stride,
    input  logic [DW-1:0] lo_in,
    output logic [DW-1:0] lo_out,
    output logic [CW-1:0] hi_count
);
    import gnb_pkg::*;

    localparam int NCODES = 2 ** NW;

    logic [CW-1:0] cnt_tab [NCODES];
    logic [CW-1:0] sft_tab [NCODES];

    for (genvar v = 0; v < NCODES; v++) begin : g_code
        if (v >= STRIDE_MIN) begin : g_legal
            assign cnt_tab[v] = CW'(ceil_div(DW, v));
            assign sft_tab[v] = CW'(v * ceil_div(DW, v) - DW);
        end else begin : g_illegal
            assign cnt_tab[v] = '0;
            assign sft_tab[v] = '0;
        end
    end

    assign hi_count = cnt_tab[stride];
    assign lo_out   = lo_in << sft_tab[stride];

endmodule

// File: rtl/gnb_unit.sv
`timescale 1ns/1ps
module gnb_unit #(
    parameter int DW = 64,
    parameter int NW = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  logic [2*DW-1:0] operand,
    input  logic [NW-1:0]   stride,
    output logic            out_valid,
    output logic            wr_en,
    output logic [DW-1:0]   result
);
    import gnb_pkg::*;

    localparam int STAGES = $clog2(DW) - 1;
    localparam int CW     = $clog2(DW) + 1;

    logic [DW-1:0] lo_aligned;
    logic [CW-1:0] hi_count;
    logic [DW-1:0] hi_packed;
    logic [DW-1:0] lo_packed;
    logic [DW-1:0] keep;
    logic [DW-1:0] gathered;
    logic          legal;

    gnb_state_e state_q, state_d;

    gnb_align #(.DW(DW), .NW(NW), .CW(CW)) u_align (
        .stride   (stride),
        .lo_in    (operand[DW-1:0]),
        .lo_out   (lo_aligned),
        .hi_count (hi_count)
    );

    gnb_compact #(.DW(DW), .NW(NW), .STAGES(STAGES)) u_hi (
        .stride (stride),
        .din    (operand[2*DW-1:DW]),
        .dout   (hi_packed)
    );

    gnb_compact #(.DW(DW), .NW(NW), .STAGES(STAGES)) u_lo (
        .stride (stride),
        .din    (lo_aligned),
        .dout   (lo_packed)
    );

    assign keep     = ~({DW{1'b1}} >> hi_count);
    assign gathered = (hi_packed & keep) | ((lo_packed & keep) >> hi_count);
    assign legal    = (stride >= NW'(STRIDE_MIN));

    always_comb begin
        if (!in_valid)  state_d = ST_IDLE;
        else if (legal) state_d = ST_WRITE;
        else            state_d = ST_SKIP;
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (rst)                      result <= '0;
        else if (state_d == ST_WRITE) result <= gathered;
    end

    always_comb begin
        unique case (state_q)
            ST_IDLE:  begin out_valid = 1'b0; wr_en = 1'b0; end
            ST_WRITE: begin out_valid = 1'b1; wr_en = 1'b1; end
            ST_SKIP:  begin out_valid = 1'b1; wr_en = 1'b0; end
            default:  begin out_valid = 1'b0; wr_en = 1'b0; end
        endcase
    end

endmodule

// File: rtl/gnb_unit_chk.sv
`timescale 1ns/1ps
module gnb_unit_chk #(
    parameter int DW = 64,
    parameter int NW = 3
) (
    input logic            clk,
    input logic            rst,
    input logic            in_valid,
    input logic [2*DW-1:0] operand,
    input logic [NW-1:0]   stride,
    input logic            out_valid,
    input logic            wr_en,
    input logic [DW-1:0]   result
);
    localparam int CW = $clog2(2*DW) + 1;

    logic [NW-1:0] last_stride;
    logic [CW-1:0] used_bits;
    logic [DW-1:0] tail_mask;

    always_ff @(posedge clk) begin
        if (rst) last_stride <= '0;
        else     last_stride <= stride;
    end

    always_comb begin
        if (last_stride >= NW'(2)) used_bits = CW'((2*DW + int'(last_stride) - 1) / int'(last_stride));
        else                       used_bits = CW'(DW);
        tail_mask = (used_bits >= CW'(DW)) ? '0 : ({DW{1'b1}} >> used_bits);
    end

    assert_issue_valid_R1: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    assert_legal_write_R1: assert property (@(posedge clk) disable iff (rst)
        (in_valid && stride >= NW'(2)) |=> wr_en);

    assert_write_has_valid_R1: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> out_valid);

    assert_top_bit_R2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && stride >= NW'(2)) |=> (result[DW-1] == $past(operand[2*DW-1])));

    assert_zero_tail_R3: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> ((result & tail_mask) == '0));

    assert_illegal_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && stride < NW'(2)) |=> (!wr_en && $stable(result)));

    assert_idle_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && !wr_en && $stable(result)));

endmodule

bind gnb_unit gnb_unit_chk #(.DW(DW), .NW(NW)) u_chk (.*);

// File: tb/sim_gnb_unit.sv
`timescale 1ns/1ps
module sim_gnb_unit;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [127:0] operand = '0;
    logic [2:0]   stride = '0;
    logic         out_valid;
    logic         wr_en;
    logic [63:0]  result;

    int errors = 0;
    int checks = 0;
    bit done   = 0;

    logic        exp_v = 1'b0;
    logic        exp_w = 1'b0;
    logic [63:0] exp_r = '0;
    logic [2:0]  exp_n = '0;
    string       exp_tag = "R7";

    always #2 clk = ~clk;

    gnb_unit u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .operand(operand),
        .stride(stride), .out_valid(out_valid), .wr_en(wr_en), .result(result)
    );

    function automatic logic [63:0] ref_gather(logic [127:0] op, int n);
        logic [63:0] r;
        r = '0;
        for (int j = 0; j * n < 128; j++) r[63-j] = op[127-j*n];
        return r;
    endfunction

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_outputs();
        string vt;
        vt = exp_v ? (exp_w ? "R1" : "R5") : (exp_tag == "R7" ? "R7" : "R6");
        check(vt, {63'd0, out_valid}, {63'd0, exp_v});
        check(vt, {63'd0, wr_en}, {63'd0, exp_w});
        check(exp_tag, result, exp_r);
        if (exp_w) begin
            int used;
            used = (128 + int'(exp_n) - 1) / int'(exp_n);
            if (used < 64) check("R3", result & ({64{1'b1}} >> used), 64'd0);
        end
    endtask

    task automatic issue(logic v, logic [127:0] op, logic [2:0] n, string tag);
        @(negedge clk);
        check_outputs();
        in_valid = v;
        operand  = op;
        stride   = n;
        exp_v    = v;
        exp_w    = v && (n >= 3'd2);
        exp_n    = n;
        if (exp_w) exp_r = ref_gather(op, int'(n));
        exp_tag  = v ? (exp_w ? tag : "R5") : "R6";
    endtask

    function automatic logic [127:0] rnd128();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    initial begin
        #(200000 * 4);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R7: reset dominates a valid issue
        in_valid = 1'b1;
        operand  = {128{1'b1}};
        stride   = 3'd2;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        in_valid = 1'b0;
        exp_tag = "R7";
        check_outputs();

        // R2/R3: patterned operands at every stride
        for (int n = 0; n < 8; n++) begin
            issue(1'b1, {128{1'b1}}, 3'(n), "R2");
            issue(1'b1, {32{4'hA}}, 3'(n), "R2");
            issue(1'b1, {32{4'h9}}, 3'(n), "R2");
            issue(1'b0, '0, 3'(n), "R6");
        end

        // R5: illegal stride after a good write keeps the old result
        issue(1'b1, {64{2'b01}}, 3'd4, "R2");
        issue(1'b1, rnd128(), 3'd0, "R5");
        issue(1'b1, rnd128(), 3'd1, "R5");

        // R4: single bits just past the doubleword boundary
        issue(1'b1, 128'd1 << 61, 3'd3, "R4");
        issue(1'b1, 128'd1 << 62, 3'd5, "R4");
        issue(1'b1, 128'd1 << 57, 3'd7, "R4");
        issue(1'b1, 128'd1 << 63, 3'd6, "R4");
        issue(1'b1, 128'd1, 3'd7, "R4");
        for (int b = 0; b < 128; b++) begin
            issue(1'b1, 128'd1 << b, 3'(2 + (b % 6)), "R4");
        end

        // R8: back-to-back random issues with mixed strides and gaps
        for (int i = 0; i < 400; i++) begin
            issue(($urandom % 5) != 0, rnd128(), 3'($urandom % 8), "R8");
        end

        issue(1'b0, '0, 3'd0, "R6");
        issue(1'b0, '0, 3'd0, "R6");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule